// File: doc/BRIEF.md
# Instruction Prefetch Queue with Deferred Execute-Never Faults

This block sits between an instruction fetch bus and the decoder. It runs ahead of execution and fetches sequential words into a small queue. After a branch prediction or an exception, the fetch stream can be pointed at a new target through the redirect input. Every word is stamped, as it enters the queue, with a no-execute flag. The flag is derived from the word's fetch address.

A fetch from a protected region is never an error in itself, whether the fetch was speculative or not. The flag only travels with the word. When the decoder actually accepts a flagged word, the block pulses a fault output carrying that word's address. It then stops issuing until the next redirect. A redirect throws away every queued word in one cycle and restarts fetching at the target. It also marks any response still in flight as stale, so that response is dropped when it arrives.

At most one fetch request is outstanding. Requests stop while the queued words plus the reserved slot would exceed the queue depth.

Top module: `xn_prefetch_queue`

## Requirements
- R1: Reset state. While reset is held and right after it, the queue is empty: `issue_valid` is 0 and `fault_valid` is 0. `fetch_req_valid` is 1 with `fetch_req_addr` equal to the reset address, which is 0 by default.
- R2: Fetch requests walk upward in steps of 4 bytes. A request is accepted in a cycle where `fetch_req_valid` and `fetch_req_ready` are both 1. The next request is not raised until the response to the previous one has arrived, so at most one request is outstanding.
- R3: Non-stale responses enter the queue in arrival order. Each one is issued with `issue_pc` equal to the address of its request and `issue_insn` equal to the response data. A word leaves the queue in a cycle where `issue_valid` and `issue_ready` are both 1.
- R4: `issue_fault` is 1 exactly when `issue_pc[31:29]` is 3'b010 or 3'b111. This covers 0x4000_0000–0x5FFF_FFFF and 0xE000_0000–0xFFFF_FFFF. Words from 0x0000_0000–0x3FFF_FFFF and 0x6000_0000–0xDFFF_FFFF are executable.
- R5: Fetching or queueing a word from a no-execute address never raises `fault_valid`. `fault_valid` rises only in the cycle after the decoder accepted a word with `issue_fault` set.
- R6: `fault_valid` is a one-cycle pulse. `fault_pc` carries the address of the accepted faulting word.
- R7: After a flagged word is accepted, `issue_valid` stays 0 until a redirect is applied. The one exception is a redirect in the same cycle as the acceptance, which takes precedence over the stop.
- R8: A redirect empties the queue, so `issue_valid` is 0 in the next cycle. The next request then goes to `redirect_target`.
- R9: A response to a request accepted before or during a redirect is discarded and never issued. This includes a response that arrives in the redirect cycle itself.
- R10: No request is raised while the queue holds DEPTH words. Once a word is consumed, `fetch_req_valid` returns in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_req_valid | output | 1 | Fetch request raised |
| fetch_req_ready | input | 1 | Bus accepts the request |
| fetch_req_addr | output | 32 | Byte address of the requested word |
| fetch_rsp_valid | input | 1 | Response data present |
| fetch_rsp_data | input | DW | Fetched instruction word |
| redirect_valid | input | 1 | Flush and restart fetching |
| redirect_target | input | 32 | New fetch address |
| issue_valid | output | 1 | Head word offered to the decoder |
| issue_ready | input | 1 | Decoder takes the head word |
| issue_insn | output | DW | Head instruction word |
| issue_pc | output | 32 | Address of the head word |
| issue_fault | output | 1 | Head word is from a no-execute address |
| fault_valid | output | 1 | One-cycle execute-never fault pulse |
| fault_pc | output | 32 | Address of the faulting word |

## Verification
Two functions can land in the same cycle and must be ranked against each other.

The first collision is a redirect against the fetch stream. The bench returns responses after a random latency and redirects on a fixed period, so a response sometimes arrives together with the redirect and sometimes one to three cycles after it. Both cases are judged as discarded words, and the behavioural model confirms that neither ever shows up on `issue_pc`.

The second collision is a redirect against a faulting acceptance. The pulse must still appear, and issuing must restart at the new target rather than stay stopped. The model resolves this with the redirect's precedence and compares every output on every clock.

// File: rtl/xn_prefetch_queue.sv
module xn_prefetch_queue #(
  parameter int          DEPTH    = 4,
  parameter int          DW       = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          fetch_req_valid,
  input  logic          fetch_req_ready,
  output logic [31:0]   fetch_req_addr,
  input  logic          fetch_rsp_valid,
  input  logic [DW-1:0] fetch_rsp_data,
  input  logic          redirect_valid,
  input  logic [31:0]   redirect_target,
  output logic          issue_valid,
  input  logic          issue_ready,
  output logic [DW-1:0] issue_insn,
  output logic [31:0]   issue_pc,
  output logic          issue_fault,
  output logic          fault_valid,
  output logic [31:0]   fault_pc
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int STEP = DW / 8;

  function automatic logic no_exec(input logic [31:0] a);
    return (a[31:29] == 3'b010) || (a[31:29] == 3'b111);
  endfunction

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [DW-1:0] insn_q [DEPTH];
  logic [31:0]   pc_q   [DEPTH];
  logic [DEPTH-1:0] xn_q;

  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;
  logic [31:0]   fetch_pc, fly_pc;
  logic          outst, stale, halted;

  logic req_fire, push, pop, fault_take, outst_next;

  assign fetch_req_valid = !outst && (count != CW'(DEPTH));
  assign fetch_req_addr  = fetch_pc;
  assign req_fire        = fetch_req_valid && fetch_req_ready;
  assign push            = fetch_rsp_valid && outst && !stale && !redirect_valid;

  assign issue_valid = (count != '0) && !halted;
  assign issue_insn  = insn_q[head];
  assign issue_pc    = pc_q[head];
  assign issue_fault = xn_q[head];
  assign pop         = issue_valid && issue_ready;
  assign fault_take  = pop && issue_fault;
  assign outst_next  = (outst && !fetch_rsp_valid) || req_fire;

  always_ff @(posedge clk) begin
    if (push) begin
      insn_q[tail] <= fetch_rsp_data;
      pc_q[tail]   <= fly_pc;
      xn_q[tail]   <= no_exec(fly_pc);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head        <= '0;
      tail        <= '0;
      count       <= '0;
      fetch_pc    <= RESET_PC;
      fly_pc      <= RESET_PC;
      outst       <= 1'b0;
      stale       <= 1'b0;
      halted      <= 1'b0;
      fault_valid <= 1'b0;
      fault_pc    <= '0;
    end else begin
      fault_valid <= fault_take;
      if (fault_take) fault_pc <= issue_pc;
      outst <= outst_next;
      if (req_fire) fly_pc <= fetch_pc;
      if (redirect_valid) begin
        head     <= '0;
        tail     <= '0;
        count    <= '0;
        fetch_pc <= redirect_target;
        stale    <= outst_next;
        halted   <= 1'b0;
      end else begin
        if (req_fire) fetch_pc <= fetch_pc + 32'(STEP);
        if (push) tail <= wrap_inc(tail);
        if (pop)  head <= wrap_inc(head);
        count <= count + CW'(push) - CW'(pop);
        stale <= stale && !fetch_rsp_valid;
        if (fault_take) halted <= 1'b1;
      end
    end
  end
endmodule

module xn_prefetch_queue_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_req_valid,
  input logic          fetch_req_ready,
  input logic          fetch_rsp_valid,
  input logic          redirect_valid,
  input logic          issue_valid,
  input logic          issue_ready,
  input logic [31:0]   issue_pc,
  input logic          issue_fault,
  input logic          fault_valid,
  input logic [31:0]   fault_pc,
  input logic [CW-1:0] count
);
  logic seen_out;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_out <= 1'b0;
    else        seen_out <= (seen_out && !fetch_rsp_valid) || (fetch_req_valid && fetch_req_ready);
  end

  p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_valid |-> !seen_out);
  p_xn_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (issue_fault == ((issue_pc[31:29] == 3'b010) || (issue_pc[31:29] == 3'b111))));
  p_fault_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> $past(issue_valid && issue_ready && issue_fault));
  p_fault_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (fault_pc == $past(issue_pc)));
  p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issue_valid && issue_ready && issue_fault && !redirect_valid) |-> !issue_valid);
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(redirect_valid) |-> !issue_valid);
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_valid |-> (int'(count) < DEPTH));
endmodule

bind xn_prefetch_queue xn_prefetch_queue_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
  .fetch_rsp_valid(fetch_rsp_valid), .redirect_valid(redirect_valid),
  .issue_valid(issue_valid), .issue_ready(issue_ready),
  .issue_pc(issue_pc), .issue_fault(issue_fault),
  .fault_valid(fault_valid), .fault_pc(fault_pc), .count(count)
);

// File: tb/xn_prefetch_queue_bench.sv
module xn_prefetch_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int CYCLES     = 4000;

  logic clk = 1'b0;
  logic rst_n;
  logic fetch_req_valid, fetch_req_ready, fetch_rsp_valid;
  logic [31:0] fetch_req_addr, fetch_rsp_data, redirect_target;
  logic redirect_valid, issue_valid, issue_ready, issue_fault, fault_valid;
  logic [31:0] issue_insn, issue_pc, fault_pc;

  int compared = 0, mismatched = 0;
  int saw_fault = 0, saw_full = 0, saw_stale = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xn_prefetch_queue #(.DEPTH(DEPTH)) u_xn_prefetch_queue (
    .clk(clk), .rst_n(rst_n),
    .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
    .fetch_req_addr(fetch_req_addr), .fetch_rsp_valid(fetch_rsp_valid),
    .fetch_rsp_data(fetch_rsp_data), .redirect_valid(redirect_valid),
    .redirect_target(redirect_target), .issue_valid(issue_valid),
    .issue_ready(issue_ready), .issue_insn(issue_insn), .issue_pc(issue_pc),
    .issue_fault(issue_fault), .fault_valid(fault_valid), .fault_pc(fault_pc)
  );

  function automatic bit xn(input logic [31:0] a);
    return (a >= 32'h4000_0000 && a <= 32'h5FFF_FFFF) || (a >= 32'hE000_0000);
  endfunction

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return {a[15:0], ~a[31:16]};
  endfunction

  function automatic logic [31:0] target_of(input int k);
    case (k % 8)
      0: return 32'h0000_0040;
      1: return 32'h4000_0000;
      2: return 32'h1FFF_FFF8;
      3: return 32'h3FFF_FFF8;
      4: return 32'hE00F_FFF8;
      5: return 32'hDFFF_FFF8;
      6: return 32'h2000_1000;
      default: return 32'h5FFF_FFF8;
    endcase
  endfunction

  logic [31:0] mq[$];
  logic [31:0] m_pc, m_fly, m_fpc, mem_addr;
  bit m_out, m_stale, m_halt, m_fault, mem_busy;
  int mem_delay, lat_next;

  always @(posedge clk) begin : model
    bit reqv, fire, rsp, pop, fnow, nout;
    logic [31:0] hd;
    if (!rst_n) begin
      mq.delete();
      m_pc = 32'h0; m_fly = 32'h0; m_fpc = 32'h0;
      m_out = 0; m_stale = 0; m_halt = 0; m_fault = 0; mem_busy = 0;
    end else begin
      reqv = !m_out && (mq.size() < DEPTH);
      fire = reqv && fetch_req_ready;
      rsp  = fetch_rsp_valid;
      pop  = (mq.size() > 0) && !m_halt && issue_ready;
      hd   = (mq.size() > 0) ? mq[0] : 32'h0;
      fnow = pop && xn(hd);
      m_fault = fnow;
      if (fnow) begin m_fpc = hd; saw_fault++; end
      if (rsp) mem_busy = 0;
      if (fire) begin mem_busy = 1; mem_addr = m_pc; mem_delay = lat_next; end
      nout = (m_out && !rsp) || fire;
      if (redirect_valid) begin
        mq.delete();
        m_halt = 0;
        if (nout) saw_stale++;
        m_stale = nout;
        m_pc = redirect_target;
      end else begin
        if (pop) void'(mq.pop_front());
        if (rsp && m_out && !m_stale) mq.push_back(m_fly);
        if (fnow) m_halt = 1;
        if (fire) begin m_fly = m_pc; m_pc = m_pc + 32'd4; end
        m_stale = m_stale && !rsp;
      end
      m_out = nout;
      if (mq.size() == DEPTH) saw_full++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit ev;
    ev = !m_out && (mq.size() < DEPTH);
    chk(fetch_req_valid == ev, "R2 R10", "fetch_req_valid", 32'(fetch_req_valid), 32'(ev));
    if (ev) chk(fetch_req_addr == m_pc, "R2 R8", "fetch_req_addr", fetch_req_addr, m_pc);
    ev = (mq.size() > 0) && !m_halt;
    chk(issue_valid == ev, "R3 R7 R8", "issue_valid", 32'(issue_valid), 32'(ev));
    if (ev) begin
      chk(issue_pc == mq[0], "R3 R9", "issue_pc", issue_pc, mq[0]);
      chk(issue_insn == word_of(mq[0]), "R3", "issue_insn", issue_insn, word_of(mq[0]));
      chk(issue_fault == xn(mq[0]), "R4", "issue_fault", 32'(issue_fault), 32'(xn(mq[0])));
    end
    chk(fault_valid == m_fault, "R5 R6", "fault_valid", 32'(fault_valid), 32'(m_fault));
    if (m_fault) chk(fault_pc == m_fpc, "R6", "fault_pc", fault_pc, m_fpc);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * (CYCLES + 200));
    mismatched++;
    $display("FAIL R1 watchdog expired, actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : driver
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    rst_n = 0; fetch_req_ready = 0; fetch_rsp_valid = 0; fetch_rsp_data = '0;
    redirect_valid = 0; redirect_target = '0; issue_ready = 0; lat_next = 0;
    repeat (3) @(negedge clk);
    chk(fetch_req_valid == 1'b1, "R1", "reset fetch_req_valid", 32'(fetch_req_valid), 32'h1);
    chk(fetch_req_addr == 32'h0, "R1", "reset fetch_req_addr", fetch_req_addr, 32'h0);
    chk(issue_valid == 1'b0, "R1", "reset issue_valid", 32'(issue_valid), 32'h0);
    chk(fault_valid == 1'b0, "R1", "reset fault_valid", 32'(fault_valid), 32'h0);
    rst_n = 1;
    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      @(negedge clk);
      compare_all();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fetch_req_ready = lfsr[0] | lfsr[1];
      issue_ready = ((cyc % 200) < 30) ? 1'b0 : (lfsr[2] | lfsr[3]);
      lat_next = int'(lfsr[5:4]);
      redirect_valid = ((cyc % 37) == 36);
      redirect_target = target_of(cyc / 37);
      fetch_rsp_valid = 0;
      if (mem_busy) begin
        if (mem_delay == 0) begin
          fetch_rsp_valid = 1;
          fetch_rsp_data = word_of(mem_addr);
        end else mem_delay--;
      end
    end
    @(negedge clk);
    compare_all();
    chk(saw_fault > 0, "R6", "faults provoked", 32'(saw_fault), 32'h1);
    chk(saw_full > 0, "R10", "queue filled", 32'(saw_full), 32'h1);
    chk(saw_stale > 0, "R9", "stale responses provoked", 32'(saw_stale), 32'h1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule